// File: doc/BRIEF.md
# Byte-to-Wide Staging Buffer

This block takes a stream of 8-bit samples that can arrive on every clock cycle and gathers them into 256-bit lines for a wide memory bus. Bytes are first packed into 32-bit words. Each word enters a word store whose capacity is set per instance in bits. A word leaves the store only after all four of its bytes have arrived. Words are moved one at a time into a 256-bit line register. When the eighth word lands, the register's full flag rises and the line waits for a grant from the bus arbiter.

While the line register is full, words stay in the store. They also stay there for as long as the arbiter withholds grant, for example during a memory refresh, and the store absorbs that backlog. A grant on a full line hands the value over, empties the register and pulses a one-cycle read strobe. If a byte arrives that would complete a word while the store is already at capacity, that byte is dropped and a sticky overflow error is raised.

Top module: `byte_wide_stager`

## Requirements
- R1: Within a 32-bit word, the first accepted byte occupies bits [7:0], the second bits [15:8], the third bits [23:16] and the fourth bits [31:24].
- R2: Within the 256-bit line, the first word moved in occupies bits [31:0] and each following word the next 32 bits up, so the eighth occupies [255:224]; consecutive lines carry the accepted bytes in arrival order with none lost or repeated.
- R3: A partial word (fewer than four bytes) never reaches the line register, so after 31 bytes the full flag stays 0 however long the input stays idle.
- R4: With the store otherwise empty and the register empty, the full flag reads 1 from the second clock edge after the edge that accepts the byte completing the eighth word, and reads 0 after the first.
- R5: Grant while the full flag is 1 clears the flag at that clock edge. The read strobe is then 1 for exactly the following cycle, and during that strobe cycle the line output still holds the granted value.
- R6: Grant while the full flag is 0 has no effect: no strobe is raised, and no buffered data is lost.
- R7: While the full flag is 1 and no grant is taken, the line output does not change. Incoming bytes queue in the store in order.
- R8: The store holds FIFO_BITS/32 complete words plus up to three pending bytes. A byte that would complete a word when the store is full is dropped, and the overflow error becomes 1. Once set, the error stays 1 until reset. It never rises while the store has room.
- R9: After synchronous reset the full flag, read strobe, overflow error and line output are all 0.
- R10: A byte presented with its valid input at 0 is ignored and does not enter any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The byte on in_byte is to be taken at this edge |
| in_byte | input | 8 | Incoming sample |
| grant | input | 1 | Bus grant; takes the line when the full flag is 1 |
| line_out | output | 256 | Staged line; word 0 in bits [31:0] |
| line_full | output | 1 | 1 when the line register holds eight words |
| rd_strobe | output | 1 | One-cycle pulse in the cycle after a line is taken |
| err_overflow | output | 1 | Sticky overflow error |

## Verification
A packing or ordering fault shows on line_out at the first granted line as bytes in the wrong lanes. A lost or duplicated word shows on a later line as a gap or a repeat in the sequence. A flag or pointer fault shows up either as line_full rising a cycle early or late, or as a strobe with no matching grant. An occupancy count that is off shows up as the overflow error firing at the wrong byte of a long stall: the bench counts the exact byte at which it must first rise. Random runs with frequent grants catch ordering faults within one or two lines, and the directed stall finds capacity faults after about 550 bytes.

// File: rtl/stager_pkg.sv
package stager_pkg;

  // Number of narrow units that fit in one wide unit
  function automatic int unsigned units_per(input int unsigned wide, input int unsigned narrow);
    return wide / narrow;
  endfunction

  // Counter width able to index n distinct values (at least one bit)
  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/byte_packer.sv
module byte_packer
  import stager_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              store_full,
  output logic              push,
  output logic [WORD_W-1:0] push_word,
  output logic              overflow
);

  localparam int unsigned LANES = units_per(WORD_W, BYTE_W);
  localparam int unsigned CW    = idx_width(LANES);
  localparam logic [CW-1:0] LAST_LANE = CW'(LANES - 1);

  logic [CW-1:0]               lane_cnt;
  logic [WORD_W-BYTE_W-1:0]    pend;
  logic                        completing;

  assign completing = in_valid && (lane_cnt == LAST_LANE);
  assign push       = completing && !store_full;
  assign push_word  = {in_byte, pend};

  // one holding register per pending lane
  for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (in_valid && lane_cnt == CW'(g)) begin
        q <= in_byte;
      end
    end
    assign pend[g*BYTE_W +: BYTE_W] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_cnt <= '0;
    end else if (in_valid) begin
      if (!completing) begin
        lane_cnt <= lane_cnt + 1'b1;
      end else if (push) begin
        lane_cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      overflow <= 1'b0;
    end else if (completing && store_full) begin
      overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/word_fifo.sv
module word_fifo
  import stager_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 128
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          push,
  input  logic [WIDTH-1:0]              wdata,
  input  logic                          pop,
  output logic [WIDTH-1:0]              rdata,
  output logic                          full,
  output logic                          empty,
  output logic [idx_width(DEPTH+1)-1:0] count
);

  localparam int unsigned AW = idx_width(DEPTH);
  localparam int unsigned CW = idx_width(DEPTH + 1);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] DEPTH_C   = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr;
  logic [AW-1:0]    rptr;

  assign full  = (count == DEPTH_C);
  assign empty = (count == '0);

  // storage without reset so it maps onto block RAM with registered read
  always_ff @(posedge clk) begin
    if (push) begin
      mem[wptr] <= wdata;
    end
    if (pop) begin
      rdata <= mem[rptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        wptr <= (wptr == LAST_ADDR) ? '0 : wptr + 1'b1;
      end
      if (pop) begin
        rptr <= (rptr == LAST_ADDR) ? '0 : rptr + 1'b1;
      end
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/line_stager.sv
module line_stager
  import stager_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LINE_W = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              store_empty,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              grant,
  output logic              pop,
  output logic [LINE_W-1:0] line_out,
  output logic              line_full,
  output logic              rd_strobe
);

  localparam int unsigned WORDS = units_per(LINE_W, WORD_W);
  localparam int unsigned SW    = idx_width(WORDS);
  localparam int unsigned IW    = idx_width(WORDS + 1);
  localparam logic [SW-1:0] LAST_SLOT = SW'(WORDS - 1);
  localparam logic [IW-1:0] WORDS_C   = IW'(WORDS);

  logic [IW-1:0] issued;
  logic [SW-1:0] wsel;
  logic          rd_valid;
  logic          take;

  assign take = grant && line_full;
  assign pop  = !line_full && (issued != WORDS_C) && !store_empty;

  // one register per 32-bit slot of the line
  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (rd_valid && wsel == SW'(g)) begin
        q <= rd_word;
      end
    end
    assign line_out[g*WORD_W +: WORD_W] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= pop;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issued <= '0;
    end else if (take) begin
      issued <= '0;
    end else if (pop) begin
      issued <= issued + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wsel <= '0;
    end else if (rd_valid) begin
      wsel <= (wsel == LAST_SLOT) ? '0 : wsel + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_full <= 1'b0;
    end else if (take) begin
      line_full <= 1'b0;
    end else if (rd_valid && wsel == LAST_SLOT) begin
      line_full <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_strobe <= 1'b0;
    end else begin
      rd_strobe <= take;
    end
  end

endmodule

// File: rtl/byte_wide_stager.sv
module byte_wide_stager
  import stager_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned LINE_W    = 256,
  parameter int unsigned FIFO_BITS = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              grant,
  output logic [LINE_W-1:0] line_out,
  output logic              line_full,
  output logic              rd_strobe,
  output logic              err_overflow
);

  localparam int unsigned DEPTH = units_per(FIFO_BITS, WORD_W);
  localparam int unsigned CNTW  = idx_width(DEPTH + 1);

  logic              push;
  logic [WORD_W-1:0] push_word;
  logic              pop;
  logic [WORD_W-1:0] rd_word;
  logic              store_full;
  logic              store_empty;
  logic [CNTW-1:0]   fifo_count;

  byte_packer #(
    .BYTE_W (BYTE_W),
    .WORD_W (WORD_W)
  ) u_packer (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .store_full (store_full),
    .push       (push),
    .push_word  (push_word),
    .overflow   (err_overflow)
  );

  word_fifo #(
    .WIDTH (WORD_W),
    .DEPTH (DEPTH)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .wdata (push_word),
    .pop   (pop),
    .rdata (rd_word),
    .full  (store_full),
    .empty (store_empty),
    .count (fifo_count)
  );

  line_stager #(
    .WORD_W (WORD_W),
    .LINE_W (LINE_W)
  ) u_line (
    .clk         (clk),
    .rst         (rst),
    .store_empty (store_empty),
    .rd_word     (rd_word),
    .grant       (grant),
    .pop         (pop),
    .line_out    (line_out),
    .line_full   (line_full),
    .rd_strobe   (rd_strobe)
  );

endmodule

// File: rtl/stager_checker.sv
module stager_checker #(
  parameter int unsigned LINE_W = 256,
  parameter int unsigned CNTW   = 8,
  parameter int unsigned DEPTH  = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              grant,
  input logic              line_full,
  input logic              rd_strobe,
  input logic              err_overflow,
  input logic [LINE_W-1:0] line_out,
  input logic [CNTW-1:0]   fifo_count
);

  // R5: a strobe only follows a grant taken on a full line
  p_strobe_after_take_r5: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |-> $past(grant && line_full));

  // R5: taking the line empties the register at that edge
  p_flag_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (grant && line_full) |=> !line_full);

  // R6: grant on an empty register raises no strobe
  p_idle_grant_r6: assert property (@(posedge clk) disable iff (rst)
    (grant && !line_full) |=> !rd_strobe);

  // R7: a held line does not change
  p_line_held_r7: assert property (@(posedge clk) disable iff (rst)
    (line_full && !grant) |=> $stable(line_out));

  // R8: overflow error is sticky
  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_overflow |=> err_overflow);

  // R8: occupancy never exceeds capacity
  p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CNTW'(DEPTH));

  // R5: strobe lasts one cycle since the flag is already clear
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> !rd_strobe);

endmodule

bind byte_wide_stager stager_checker #(
  .LINE_W (LINE_W),
  .CNTW   (CNTW),
  .DEPTH  (DEPTH)
) u_checker (
  .clk          (clk),
  .rst          (rst),
  .grant        (grant),
  .line_full    (line_full),
  .rd_strobe    (rd_strobe),
  .err_overflow (err_overflow),
  .line_out     (line_out),
  .fifo_count   (fifo_count)
);

// File: tb/byte_wide_stager_test.sv
module byte_wide_stager_test;

  localparam int CLK_PERIOD = 10;
  localparam int LINE_W     = 256;
  localparam int FIFO_BITS  = 4096;
  localparam int DEPTH      = FIFO_BITS / 32;
  localparam int ACCEPT_MAX = 32 + DEPTH * 4 + 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [7:0]        in_byte = '0;
  logic              grant = 1'b0;
  logic [LINE_W-1:0] line_out;
  logic              line_full;
  logic              rd_strobe;
  logic              err_overflow;

  int checks = 0;
  int fails  = 0;
  bit mon_en = 1'b0;
  logic [7:0] exp_q [$];
  logic [7:0] seq = 8'd0;

  byte_wide_stager #(.FIFO_BITS(FIFO_BITS)) uut (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_byte      (in_byte),
    .grant        (grant),
    .line_out     (line_out),
    .line_full    (line_full),
    .rd_strobe    (rd_strobe),
    .err_overflow (err_overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [LINE_W-1:0] act,
                     input logic [LINE_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [LINE_W-1:0] next_line();
    logic [LINE_W-1:0] v = '0;
    for (int i = 0; i < 32; i++) begin
      if (exp_q.size() > 0) v[i*8 +: 8] = exp_q.pop_front();
    end
    return v;
  endfunction

  // set inputs, let one rising edge take them, settle
  task automatic cyc(input bit v, input logic [7:0] b, input bit g, input bit queue_it);
    in_valid = v;
    in_byte  = b;
    grant    = g;
    if (v && queue_it) exp_q.push_back(b);
    @(posedge clk);
    #2;
  endtask

  task automatic send_seq(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, seq, 1'b0, 1'b1);
      seq = seq + 8'd1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'hA5, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    exp_q.delete();
    seq = 8'd0;
  endtask

  // monitor: R5 strobe timing, R1/R2 line content on every taken line
  logic prev_take = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      prev_take = 1'b0;
    end else if (mon_en) begin
      if (rd_strobe !== prev_take)
        chk(1'b0, "R5 strobe follows take", LINE_W'(rd_strobe), LINE_W'(prev_take));
      if (rd_strobe) begin
        logic [LINE_W-1:0] e;
        e = next_line();
        chk(line_out === e, "R1 R2 line content", line_out, e);
      end
      prev_take = grant && line_full;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    idle(1);
    do_reset();
    // R9 reset state
    chk(line_full == 1'b0, "R9 flag after reset", LINE_W'(line_full), '0);
    chk(rd_strobe == 1'b0, "R9 strobe after reset", LINE_W'(rd_strobe), '0);
    chk(err_overflow == 1'b0, "R9 overflow after reset", LINE_W'(err_overflow), '0);
    chk(line_out == '0, "R9 line after reset", line_out, '0);
    mon_en = 1'b1;

    // R3: 31 bytes never fill the line
    send_seq(31);
    idle(20);
    chk(line_full == 1'b0, "R3 partial word held", LINE_W'(line_full), '0);
    // R4: completing byte then two edges
    send_seq(1);
    chk(line_full == 1'b0, "R4 flag at edge 0", LINE_W'(line_full), '0);
    idle(1);
    chk(line_full == 1'b0, "R4 flag at edge 1", LINE_W'(line_full), '0);
    idle(1);
    chk(line_full == 1'b1, "R4 flag at edge 2", LINE_W'(line_full), 1);
    begin
      logic [LINE_W-1:0] e;
      for (int i = 0; i < 32; i++) e[i*8 +: 8] = 8'(i);
      chk(line_out == e, "R1 R2 first line layout", line_out, e);
      // R5: take the line
      cyc(1'b0, 8'h00, 1'b1, 1'b0);
      chk(line_full == 1'b0, "R5 flag cleared", LINE_W'(line_full), '0);
      chk(rd_strobe == 1'b1, "R5 strobe high", LINE_W'(rd_strobe), 1);
      chk(line_out == e, "R5 line held in strobe cycle", line_out, e);
      idle(1);
      chk(rd_strobe == 1'b0, "R5 strobe one cycle", LINE_W'(rd_strobe), '0);
    end

    // R6: grant on an empty register
    send_seq(10);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    chk(rd_strobe == 1'b0, "R6 idle grant no strobe", LINE_W'(rd_strobe), '0);
    chk(line_full == 1'b0, "R6 idle grant flag", LINE_W'(line_full), '0);
    // R10: invalid bytes interleaved, must not enter words
    for (int i = 0; i < 22; i++) begin
      cyc(1'b0, 8'hEE, 1'b0, 1'b0);
      send_seq(1);
    end
    idle(4);
    chk(line_full == 1'b1, "R10 line full from valid bytes only", LINE_W'(line_full), 1);

    // R7: hold the line while more bytes arrive
    begin
      logic [LINE_W-1:0] held;
      held = line_out;
      send_seq(64);
      chk(line_out == held, "R7 held line stable", line_out, held);
      cyc(1'b0, 8'h00, 1'b1, 1'b0);
      idle(12);
      cyc(1'b0, 8'h00, 1'b1, 1'b0);
      idle(12);
      cyc(1'b0, 8'h00, 1'b1, 1'b0);
      idle(2);
      chk(exp_q.size() == 0, "R2 all queued bytes delivered", LINE_W'(exp_q.size()), '0);
    end

    // random phase: frequent grants, content checked by monitor
    for (int i = 0; i < 4000; i++) begin
      bit v;
      bit g;
      v = ($urandom % 10) < 9;
      g = ($urandom % 3) == 0;
      cyc(v, 8'($urandom), g, 1'b1);
    end
    chk(err_overflow == 1'b0, "R8 no false overflow", LINE_W'(err_overflow), '0);

    // R8: long stall with no grant
    do_reset();
    send_seq(ACCEPT_MAX);
    chk(err_overflow == 1'b0, "R8 no overflow at capacity", LINE_W'(err_overflow), '0);
    cyc(1'b1, 8'hDD, 1'b0, 1'b0);
    chk(err_overflow == 1'b1, "R8 overflow on extra byte", LINE_W'(err_overflow), 1);
    idle(3);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    idle(12);
    chk(err_overflow == 1'b1, "R8 overflow sticky", LINE_W'(err_overflow), 1);
    mon_en = 1'b0;
    do_reset();
    chk(err_overflow == 1'b0, "R9 reset clears overflow", LINE_W'(err_overflow), '0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule